// File: doc/BRIEF.md
# Double-Buffered DAC Register Bank

This block keeps the digital codes for a bank of voltage-output DAC channels in two register levels per channel. A completed write from the serial front end lands in a staging register. A second, output register feeds the conversion stage. Moving codes from staging to output is governed by two things: a 2-bit software transfer mode, and an active-low hardware load pin that may change with no relation to the clock. A software-selected transparent mode makes the output level follow every write. A latched mode freezes the outputs until the load pin is taken low.

Each channel carries a pending flag. The flag is raised by a write and dropped when that channel's output register is refreshed. A transfer event therefore touches only the channels that have new data, and each refreshed channel raises a one-cycle update strobe. Several channels can be staged while the pin is high. Lowering the pin at the same time as the last write then refreshes all of them on the same clock edge. A data clear empties both levels and drops every pending flag.

Top module: `dac_dbuf_bank`

## Requirements
- R1: During and after a synchronous reset, every output code is 0 and every update strobe is 0.
- R2: A write changes only the staging register of the channel selected by `wr_ch`. A later transfer refreshes that channel alone, with bit `wr_ch` of `upd_stb` set and all other codes unchanged.
- R3: With `ld_mode` = 2'b00 (transparent), a write sampled at edge N appears on that channel's output after edge N+1. The channel's strobe is high for that one cycle.
- R4: With `ld_mode` equal to 2'b01, 2'b10 or 2'b11 and `load_n` held high, output codes and strobes stay unchanged while staging registers are written.
- R5: `load_n` passes through a two-flop synchronizer. A low level sampled at edge N transfers the pending channels at edge N+2, and they are visible after that edge. The transfer repeats on every cycle the synchronized level stays low.
- R6: While the synchronized `load_n` is low, a write sampled at edge N reaches the output after edge N+1, whatever the value of `ld_mode`.
- R7: A channel's output register and strobe change only when its pending flag is set. Holding `load_n` low with no writes produces no strobes.
- R8: A write in the same cycle as a transfer of that channel leaves its pending flag set. Back-to-back writes in transparent mode therefore give two consecutive strobes, and the output ends at the second value.
- R9: Seven channels written with `load_n` high, then the eighth written in the cycle `load_n` falls, all refresh on one edge (`upd_stb` = 8'hFF).
- R10: `clr_data` empties both register levels and all pending flags in one cycle. It takes priority over a write in the same cycle, and a later load event produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle pulse marking a completed valid write |
| wr_ch | input | 3 | Channel selected by the write |
| wr_code | input | 12 | Code written to the staging register |
| ld_mode | input | 2 | Transfer mode: 00 transparent, others latched |
| load_n | input | 1 | Asynchronous active-low load pin |
| clr_data | input | 1 | Clears both register levels and pending flags |
| dac_codes | output | 96 | Output codes, channel k at bits [12k+11:12k] |
| upd_stb | output | 8 | One-cycle strobe per channel refreshed in that cycle |

## Verification
The bench goes after three things: the exact latency of the synchronizer path, a write that collides with a transfer, and a load held low with no new data. A design that dropped a synchronizer stage would refresh one cycle early. One that cleared the pending flag on a colliding write would leave the first of two back-to-back values on the output. One that ignored the flags would fire strobes on every low cycle. The simultaneous-refresh case and the clear-over-write priority are also swept. A wrong design would split the eight strobes across two cycles in the first case, and in the second would let a cleared channel come back with stale data.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    localparam int unsigned CH_COUNT_DEF = 8;
    localparam int unsigned CODE_W_DEF   = 12;
    localparam int unsigned SYNC_LEN_DEF = 2;

    typedef enum logic [1:0] {
        XFER_FOLLOW  = 2'b00,
        XFER_HOLD    = 2'b01,
        XFER_HOLD_B  = 2'b10,
        XFER_HOLD_C  = 2'b11
    } xfer_mode_e;

    // A transfer is enabled in transparent mode or while the synced pin is low.
    function automatic logic xfer_enabled(input xfer_mode_e mode, input logic pin_low);
        return (mode == XFER_FOLLOW) || pin_low;
    endfunction

endpackage

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], pin_n};
    end

    assign sync_n = chain_q[STAGES-1];

    // R5: synced level equals pin two edges back once reset has been gone two cycles
    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (sync_n == $past(pin_n, 2)));

endmodule

// File: rtl/dac_xfer_gate.sv
module dac_xfer_gate
    import dac_dbuf_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sync_n,
    output logic       xfer
);
    xfer_mode_e mode_e;

    always_comb begin
        mode_e = xfer_mode_e'(mode);
        xfer   = xfer_enabled(mode_e, !sync_n);
    end

endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              xfer,
    output logic [CODE_W-1:0] out_code,
    output logic              stb
);
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] out_q;
    logic              pend_q;
    logic              stb_q;
    logic              copy;

    assign copy = xfer && pend_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stage_q <= '0;
            out_q   <= '0;
            pend_q  <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            if (wr_hit) stage_q <= wr_code;
            if (copy)   out_q   <= stage_q;
            stb_q  <= copy;
            pend_q <= wr_hit || (pend_q && !copy);
        end
    end

    assign out_code = out_q;
    assign stb      = stb_q;

    // R4: no transfer enable means the output level holds
    assert_hold_no_xfer_R4: assert property (@(posedge clk) disable iff (rst)
        (!xfer && !clr) |=> $stable(out_code));

    // R7: a channel with no pending data never changes
    assert_clean_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !clr) |=> ($stable(out_code) && !stb));

    // R8: a write always leaves the pending flag set
    assert_write_pends_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !clr) |=> pend_q);

    // R3: a strobe shows the staged code of the cycle before
    assert_strobe_data_R3: assert property (@(posedge clk) disable iff (rst)
        stb |-> (out_code == $past(stage_q)));

    // R10: clear empties the output and the pending flag
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (out_code == '0 && !pend_q && !stb));

endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned CH_COUNT = CH_COUNT_DEF,
    parameter int unsigned CODE_W   = CODE_W_DEF,
    parameter int unsigned SYNC_LEN = SYNC_LEN_DEF,
    localparam int unsigned CH_W    = $clog2(CH_COUNT)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [CH_W-1:0]            wr_ch,
    input  logic [CODE_W-1:0]          wr_code,
    input  logic [1:0]                 ld_mode,
    input  logic                       load_n,
    input  logic                       clr_data,
    output logic [CH_COUNT*CODE_W-1:0] dac_codes,
    output logic [CH_COUNT-1:0]        upd_stb
);
    logic sync_n;
    logic xfer;

    dac_load_sync #(.STAGES(SYNC_LEN)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (load_n),
        .sync_n (sync_n)
    );

    dac_xfer_gate gate_i (
        .mode   (ld_mode),
        .sync_n (sync_n),
        .xfer   (xfer)
    );

    for (genvar k = 0; k < CH_COUNT; k++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CH_W'(k));

        dac_chan_slice #(.CODE_W(CODE_W)) ch_i (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr_data),
            .wr_hit   (hit),
            .wr_code  (wr_code),
            .xfer     (xfer),
            .out_code (dac_codes[k*CODE_W +: CODE_W]),
            .stb      (upd_stb[k])
        );
    end

    // R1: reset leaves no strobe behind
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (upd_stb == '0 && dac_codes == '0));

    // R2: a single write can raise at most one pending strobe path per cycle
    assert_one_write_R2: assert property (@(posedge clk) disable iff (rst)
        (ld_mode == 2'b00 && sync_n && $past(sync_n) && !$past(clr_data))
            |-> $onehot0(upd_stb));

endmodule

// File: tb/dac_dbuf_bank_tb_top.sv
module dac_dbuf_bank_tb_top;
    localparam int NCH = 8;
    localparam int CW  = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_ch = '0;
    logic [CW-1:0]   wr_code = '0;
    logic [1:0]      ld_mode = 2'b01;
    logic            load_n = 1'b1;
    logic            clr_data = 1'b0;
    logic [NCH*CW-1:0] dac_codes;
    logic [NCH-1:0]  upd_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [CW-1:0] exp_out [NCH];

    always #10 clk = ~clk;

    dac_dbuf_bank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
        .ld_mode(ld_mode), .load_n(load_n), .clr_data(clr_data),
        .dac_codes(dac_codes), .upd_stb(upd_stb)
    );

    function automatic logic [CW-1:0] code_of(input int ch);
        return dac_codes[ch*CW +: CW];
    endfunction

    function automatic logic [CW-1:0] pat(input int ch, input int k);
        return CW'((ch * 397 + k * 1021 + 5) % 4096);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_stb(input logic [NCH-1:0] exp, input string req);
        checks++;
        if (upd_stb !== exp) begin
            fails++;
            $display("FAIL %s strobe actual=%b expected=%b", req, upd_stb, exp);
        end
    endtask

    task automatic chk_code(input int ch, input logic [CW-1:0] exp, input string req);
        checks++;
        if (code_of(ch) !== exp) begin
            fails++;
            $display("FAIL %s ch%0d code actual=%h expected=%h", req, ch, code_of(ch), exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < NCH; c++) chk_code(c, exp_out[c], req);
    endtask

    task automatic wr(input int ch, input logic [CW-1:0] v);
        wr_en = 1'b1; wr_ch = 3'(ch); wr_code = v;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) exp_out[c] = '0;
        @(negedge clk);
        tick(); tick();
        // R1 during reset
        chk_all("R1"); chk_stb('0, "R1");
        rst = 1'b0;
        tick();
        chk_all("R1"); chk_stb('0, "R1");

        // R3 transparent sweep
        ld_mode = 2'b00;
        for (int c = 0; c < NCH; c++) begin
            wr(c, pat(c, 1));
            chk_code(c, exp_out[c], "R3");
            tick();
            exp_out[c] = pat(c, 1);
            chk_code(c, exp_out[c], "R3");
            chk_stb(8'(1 << c), "R3");
        end
        tick();
        chk_stb('0, "R3");
        chk_all("R3");

        // R8 back-to-back writes colliding with transfer
        wr(1, 12'hA5A);
        wr(1, 12'h3C3);
        chk_code(1, 12'hA5A, "R8"); chk_stb(8'h02, "R8");
        tick();
        chk_code(1, 12'h3C3, "R8"); chk_stb(8'h02, "R8");
        tick();
        chk_stb('0, "R8");
        exp_out[1] = 12'h3C3;

        // R4 latched modes hold, R5 load pulse transfers
        for (int m = 1; m < 4; m++) begin
            ld_mode = 2'(m);
            for (int c = 0; c < NCH; c++) begin
                wr(c, pat(c, m + 2));
                chk_stb('0, "R4");
            end
            tick();
            chk_all("R4"); chk_stb('0, "R4");
            load_n = 1'b0;
            tick(); tick();
            chk_stb('0, "R5"); chk_all("R5");
            tick();
            for (int c = 0; c < NCH; c++) exp_out[c] = pat(c, m + 2);
            chk_stb(8'hFF, "R5"); chk_all("R5");
            load_n = 1'b1;
            tick();
            chk_stb('0, "R7");
            tick(); tick();
        end

        // R2 single channel in latched mode
        ld_mode = 2'b01;
        wr(5, 12'h777);
        tick();
        chk_all("R2");
        load_n = 1'b0;
        tick(); tick(); tick();
        exp_out[5] = 12'h777;
        chk_stb(8'h20, "R2"); chk_all("R2");

        // R7 pin held low, no writes
        for (int i = 0; i < 5; i++) begin
            tick();
            chk_stb('0, "R7");
        end
        chk_all("R7");

        // R6 synchronous update with pin low
        for (int c = 0; c < NCH; c++) begin
            wr(c, pat(c, 9));
            tick();
            exp_out[c] = pat(c, 9);
            chk_code(c, exp_out[c], "R6"); chk_stb(8'(1 << c), "R6");
        end

        // R9 simultaneous refresh
        load_n = 1'b1;
        tick(); tick(); tick();
        for (int c = 0; c < NCH - 1; c++) wr(c, pat(c, 11));
        tick();
        chk_all("R9"); chk_stb('0, "R9");
        load_n = 1'b0;
        wr(7, pat(7, 11));
        tick();
        chk_stb('0, "R9");
        tick();
        for (int c = 0; c < NCH; c++) exp_out[c] = pat(c, 11);
        chk_stb(8'hFF, "R9"); chk_all("R9");
        load_n = 1'b1;
        tick(); tick(); tick();

        // R10 clear with pending data and a colliding write
        wr(2, 12'h123); wr(4, 12'h456);
        clr_data = 1'b1; wr_en = 1'b1; wr_ch = 3'd3; wr_code = 12'hFFF;
        tick();
        clr_data = 1'b0; wr_en = 1'b0;
        for (int c = 0; c < NCH; c++) exp_out[c] = '0;
        chk_all("R10"); chk_stb('0, "R10");
        load_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk_stb('0, "R10");
        end
        chk_all("R10");
        load_n = 1'b1;
        ld_mode = 2'b00;
        tick(); tick(); tick();
        chk_all("R10"); chk_stb('0, "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule